// File: doc/BRIEF.md
# Programmable Half-Step Clock Divider

This block turns one fast input clock into a slower output clock whose ratio is set by a 32-bit configuration word. A free-running prescaler gives reference phases for the input divided by 2, 4 and 16. A two-bit source code picks one of these or the undivided input. The main divider then divides the chosen source by an integer ratio, or by that ratio plus one half.

All timing is kept in units of input half-cycles. The output comes from a pair of flops, one on each input edge, joined by an exclusive-or. Because of this, a half-step ratio on the undivided source can end a period on a falling input edge without a glitch. The word is sampled continuously. A new setting is taken up only while the divider is stopped, or at the instant one full output period ends. When enabled from a stopped state, the divider starts on a rising edge of the selected prescaled clock.

Top module: `hdiv_top`

## Requirements
- R1: While `rstN` is low and after its release, `clkOut` is low. The held setting is: disabled, source code 00, no half step, divide value 1. The output stays low until an enabled word is applied.
- R2: The word fields are: bit 31 enable, bits 12:11 source code, bit 10 half-step flag, bits 9:0 divide value D. All other bits are ignored.
- R3: Source code 00 selects input/16, 01 selects input/4, 10 selects input/2 and 11 selects the undivided input. The source half-period S is 16, 4, 2 or 1 input half-cycles.
- R4: With the half-step flag clear, the output period is (D+1) source periods. The high phase and the low phase each last (D+1)*S input half-cycles.
- R5: With the half-step flag set, the period is D+1.5 source periods. The high phase lasts (D+2)*S input half-cycles and the low phase lasts (D+1)*S.
- R6: After the enable bit is cleared and the current period ends, the output stays low and no further edges occur. Re-enabling begins a new period from its start, not from where counting stopped.
- R7: A new word takes effect only at the end of a complete output period. Every high and low phase has the full length of either the old setting or the new one, and a disable also waits for the period end.
- R8: On enabling from a stopped state, the first rising output edge follows an input rising edge whose index since reset release is a multiple of the selected prescale factor. The index counts from 0 at the first rising edge with `rstN` high.
- R9: The largest divide value, 1023, gives a ratio of 1024, with high and low phases of 1024*S input half-cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkIn | input | 1 | Fast input clock; both edges are used |
| rstN | input | 1 | Synchronous active-low reset |
| cfgWord | input | 32 | Configuration word (enable, source, half step, divide value) |
| clkOut | output | 1 | Divided output clock |

## Verification
The bench measures every high and low phase of the output in input half-cycles and compares each one with lengths derived from the requirements. The settings cover integer ratios on the undivided source, which test the base arithmetic. They cover half-step ratios with odd period lengths, which force boundaries onto falling input edges. Each of the three prescaled sources is tried, which exposes errors in the code-to-factor mapping. The extreme divide value 1023 is also run. A setting change and a disable are both applied in the middle of a high phase, where an early reload would show up as a phase that matches neither setting. A restart from the stopped state checks that the first edge lines up with the prescaler.

// File: rtl/hdiv_pkg.sv
package hdiv_pkg;

  localparam int DIV_W = 10;
  localparam int MAX_SHIFT = 4;

  typedef enum logic [1:0] {
    SRC_DIV16  = 2'b00,
    SRC_DIV4   = 2'b01,
    SRC_DIV2   = 2'b10,
    SRC_DIRECT = 2'b11
  } srcSel_e;

  typedef struct packed {
    logic             en;
    srcSel_e          src;
    logic             halfStep;
    logic [DIV_W-1:0] div;
  } divCfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic step;   // advance the period position this input cycle
    logic midEn;  // a period boundary that falls mid-cycle starts a new period
  } divCmd_t;

  function automatic divCfg_t unpackCfg(input logic [31:0] w);
    divCfg_t c;
    c.en       = w[31];
    c.src      = srcSel_e'(w[12:11]);
    c.halfStep = w[10];
    c.div      = w[DIV_W-1:0];
    return c;
  endfunction

  // log2 of the source half-period measured in input half-cycles
  function automatic logic [2:0] srcShift(input srcSel_e s);
    case (s)
      SRC_DIV16: return 3'd4;
      SRC_DIV4:  return 3'd2;
      SRC_DIV2:  return 3'd1;
      default:   return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/hdiv_prescaler.sv
module hdiv_prescaler
  import hdiv_pkg::*;
#(
  parameter int PRE_W = 4
) (
  input  logic    clkIn,
  input  logic    rstN,
  input  srcSel_e src,
  output logic    aligned
);

  logic [PRE_W-1:0] cnt;
  logic [PRE_W-1:0] mask;

  always_ff @(posedge clkIn) begin
    if (!rstN) cnt <= '0;
    else       cnt <= cnt + 1'b1;
  end

  // a prescaled clock rises when its low counter bits are all zero
  always_comb begin
    mask    = PRE_W'((32'd1 << srcShift(src)) - 32'd1);
    aligned = (cnt & mask) == '0;
  end

  a_r3_prescale_count: assert property (@(posedge clkIn) disable iff (!rstN)
    1'b1 |=> cnt == PRE_W'($past(cnt) + 1'b1));

endmodule

// File: rtl/hdiv_ctrl.sv
module hdiv_ctrl
  import hdiv_pkg::*;
(
  input  logic        clkIn,
  input  logic        rstN,
  input  logic [31:0] cfgWord,
  input  logic        aligned,
  input  logic        atMid,
  input  logic        atEnd,
  output divCfg_t     act,
  output divCmd_t     cmd
);

  localparam divCfg_t RESET_CFG = '{en: 1'b0, src: SRC_DIV16, halfStep: 1'b0,
                                    div: DIV_W'(1)};

  divCfg_t incoming;
  logic    running;

  always_comb begin
    incoming  = unpackCfg(cfgWord);
    cmd.step  = running || (act.en && aligned);
    cmd.midEn = incoming.en;
  end

  always_ff @(posedge clkIn) begin
    if (!rstN) begin
      act     <= RESET_CFG;
      running <= 1'b0;
    end else if (!running) begin
      if (act.en && aligned) running <= 1'b1;
      else                   act     <= incoming;
    end else if (atMid || atEnd) begin
      act     <= incoming;
      running <= incoming.en;
    end
  end

  // R7: the setting in use holds for the whole of a running period
  a_r7_cfg_hold: assert property (@(posedge clkIn) disable iff (!rstN)
    (running && !atMid && !atEnd) |=> $stable(act));

  // R8: a start from the stopped state happens only on a prescaler edge
  a_r8_start_aligned: assert property (@(posedge clkIn) disable iff (!rstN)
    $rose(running) |-> $past(aligned));

endmodule

// File: rtl/hdiv_datapath.sv
module hdiv_datapath
  import hdiv_pkg::*;
#(
  parameter int POS_W = 17
) (
  input  logic    clkIn,
  input  logic    rstN,
  input  divCfg_t act,
  input  divCmd_t cmd,
  output logic    atMid,
  output logic    atEnd,
  output logic    clkOut
);

  logic [2:0]       shift;
  logic [POS_W-1:0] baseHi, basePer, hiLen, perLen;
  logic [POS_W-1:0] pos, posB, posC, posNext;
  logic             lvlA, lvlB, lvlBq;
  logic             edgeP, edgeN;

  // position counts input half-cycles; each input cycle covers pos and pos+1
  always_comb begin
    shift   = srcShift(act.src);
    baseHi  = POS_W'(act.div) + POS_W'(act.halfStep) + POS_W'(1);
    basePer = (POS_W'(act.div) << 1) + POS_W'(act.halfStep) + POS_W'(2);
    hiLen   = baseHi << shift;
    perLen  = basePer << shift;
    posB    = pos + POS_W'(1);
    posC    = pos + POS_W'(2);
    atMid   = cmd.step && (posB == perLen);
    atEnd   = cmd.step && !atMid && (posC == perLen);
    lvlA    = cmd.step && (pos < hiLen);
    if (atMid) begin
      lvlB    = cmd.midEn;
      posNext = cmd.midEn ? POS_W'(1) : '0;
    end else begin
      lvlB    = cmd.step && (posB < hiLen);
      posNext = (!cmd.step || atEnd) ? '0 : posC;
    end
  end

  always_ff @(posedge clkIn) begin
    if (!rstN) begin
      pos   <= '0;
      edgeP <= 1'b0;
      lvlBq <= 1'b0;
    end else begin
      pos   <= posNext;
      edgeP <= lvlA ^ edgeN;
      lvlBq <= lvlB;
    end
  end

  always_ff @(negedge clkIn) begin
    if (!rstN) edgeN <= 1'b0;
    else       edgeN <= lvlBq ^ edgeP;
  end

  assign clkOut = edgeP ^ edgeN;

  // R4/R5: the position never leaves the current period
  a_r5_pos_in_period: assert property (@(posedge clkIn) disable iff (!rstN)
    cmd.step |-> pos < perLen);

  // R6: a cycle without a step leaves the output low through its second half
  a_r6_idle_low: assert property (@(posedge clkIn) disable iff (!rstN)
    !cmd.step |=> clkOut == 1'b0);

endmodule

// File: rtl/hdiv_top.sv
module hdiv_top
  import hdiv_pkg::*;
#(
  parameter int PRE_W = MAX_SHIFT
) (
  input  logic        clkIn,
  input  logic        rstN,
  input  logic [31:0] cfgWord,
  output logic        clkOut
);

  localparam int POS_W = DIV_W + 3 + MAX_SHIFT;

  divCfg_t act;
  divCmd_t cmd;
  logic    aligned, atMid, atEnd;

  hdiv_prescaler #(.PRE_W(PRE_W)) uPre (
    .clkIn(clkIn), .rstN(rstN), .src(act.src), .aligned(aligned)
  );

  hdiv_ctrl uCtrl (
    .clkIn(clkIn), .rstN(rstN), .cfgWord(cfgWord), .aligned(aligned),
    .atMid(atMid), .atEnd(atEnd), .act(act), .cmd(cmd)
  );

  hdiv_datapath #(.POS_W(POS_W)) uDp (
    .clkIn(clkIn), .rstN(rstN), .act(act), .cmd(cmd),
    .atMid(atMid), .atEnd(atEnd), .clkOut(clkOut)
  );

endmodule

// File: tb/tb_hdiv_top.sv
module tb_hdiv_top;

  logic        clkIn = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] cfgWord = 32'd0;
  logic        clkOut;

  hdiv_top dut (.clkIn(clkIn), .rstN(rstN), .cfgWord(cfgWord), .clkOut(clkOut));

  always #2 clkIn = ~clkIn;   // 250 MHz

  int nCmp = 0, nBad = 0;
  int cyc = 0;
  int riseCyc = -1;
  int runLen = 0, runsDone = 0;
  logic lastLvl = 1'b0;
  int expHi = 0, expLo = 0, skip = 0;
  bit chkRuns = 0;
  string runTag = "";
  bit chkRunt = 0;
  int runtSkip = 0, aHi = 0, aLo = 0, bHi = 0, bLo = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int hOf(input int sel);
    return (sel == 0) ? 16 : (sel == 1) ? 4 : (sel == 2) ? 2 : 1;
  endfunction

  function automatic logic [31:0] cfgOf(input int en, input int sel, input int half, input int dv);
    logic [31:0] w = 32'h0;
    w[31]    = en[0];
    w[12:11] = sel[1:0];
    w[10]    = half[0];
    w[9:0]   = dv[9:0];
    w[20]    = 1'b1;   // R2: an unused bit, must be ignored
    return w;
  endfunction

  task automatic endRun(input logic lvl, input int len);
    runsDone++;
    if (chkRuns) begin
      if (skip > 0) skip--;
      else check(len == (lvl ? expHi : expLo), runTag, len, lvl ? expHi : expLo);
    end
    if (chkRunt) begin
      if (runtSkip > 0) runtSkip--;
      else check(len == (lvl ? aHi : aLo) || len == (lvl ? bHi : bLo),
                 "R7", len, lvl ? aHi : aLo);
    end
  endtask

  task automatic sampleOut(input bit atPos);
    if (clkOut === lastLvl) runLen++;
    else begin
      if (runLen > 0) endRun(lastLvl, runLen);
      if (clkOut === 1'b1 && atPos) riseCyc = cyc - 1;
      lastLvl = clkOut;
      runLen  = 1;
    end
  endtask

  always @(posedge clkIn) begin
    if (!rstN) cyc <= 0;
    else       cyc <= cyc + 1;
  end

  always @(posedge clkIn) begin #1; sampleOut(1'b1); end
  always @(negedge clkIn) begin #1; sampleOut(1'b0); end

  task automatic measure(input int sel, input int half, input int dv,
                         input string tag, input int nRuns);
    int target;
    @(negedge clkIn);
    expHi   = (dv + 1 + half) * hOf(sel);
    expLo   = (dv + 1) * hOf(sel);
    runTag  = tag;
    skip    = 3;
    chkRuns = 1;
    cfgWord = cfgOf(1, sel, half, dv);
    target  = runsDone + 3 + nRuns;
    wait (runsDone >= target);
    chkRuns = 0;
  endtask

  initial begin
    int r0, target;
    // R1: reset
    repeat (4) @(posedge clkIn);
    @(negedge clkIn); #1;
    check(clkOut === 1'b0, "R1", clkOut, 0);
    @(posedge clkIn); #1;
    rstN = 1'b1;
    r0 = runsDone;
    repeat (40) @(posedge clkIn);
    #1;
    check(runsDone == r0 && clkOut === 1'b0, "R1", runsDone - r0, 0);

    // R4: integer ratios on the undivided source
    measure(3, 0, 1, "R4", 4);
    measure(3, 0, 4, "R4", 4);
    // R5: half-step ratios, odd period on the undivided source
    measure(3, 1, 1, "R5", 4);
    measure(3, 1, 2, "R5", 4);
    measure(2, 1, 3, "R5", 4);
    // R3: each prescaled source
    measure(0, 0, 2, "R3", 2);
    measure(1, 0, 2, "R3", 2);
    measure(2, 0, 2, "R3", 2);
    // R2: field placement with all fields nonzero
    measure(1, 1, 5, "R2", 4);
    // R9: largest divide value
    measure(3, 0, 1023, "R9", 2);

    // R7: change in the middle of a high phase
    measure(2, 0, 4, "R4", 2);
    repeat (3) @(posedge clkIn);
    @(negedge clkIn);
    aHi = 10; aLo = 10; bHi = 4; bLo = 3;
    runtSkip = 1; chkRunt = 1;
    cfgWord = cfgOf(1, 3, 1, 2);
    target = runsDone + 7;
    wait (runsDone >= target);
    chkRunt = 0;

    // R7 + R6: disable in mid-period, then stays low
    @(posedge clkIn);
    @(negedge clkIn);
    aHi = 4; aLo = 3; bHi = 4; bLo = 3;
    runtSkip = 1; chkRunt = 1;
    cfgWord = cfgOf(0, 3, 1, 2);
    repeat (30) @(posedge clkIn);
    chkRunt = 0;
    #1;
    r0 = runsDone;
    repeat (40) @(posedge clkIn);
    #1;
    check(runsDone == r0 && clkOut === 1'b0, "R6", runsDone - r0, 0);

    // R6 + R8: restart from idle on the divide-by-16 source
    @(negedge clkIn);
    riseCyc = -1;
    expHi = 32; expLo = 32; runTag = "R6"; skip = 1; chkRuns = 1;
    cfgWord = cfgOf(1, 0, 0, 1);
    target = runsDone + 1 + 2;
    wait (riseCyc >= 0);
    check(riseCyc % 16 == 0, "R8", riseCyc % 16, 0);
    wait (runsDone >= target);
    chkRuns = 0;

    // R8 again on the divide-by-4 source after a stop
    @(negedge clkIn);
    cfgWord = cfgOf(0, 1, 0, 2);
    repeat (80) @(posedge clkIn);
    @(posedge clkIn);
    repeat (3) @(posedge clkIn);
    @(negedge clkIn);
    riseCyc = -1;
    cfgWord = cfgOf(1, 1, 0, 2);
    wait (riseCyc >= 0);
    check(riseCyc % 4 == 0, "R8", riseCyc % 4, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clkIn);
    if (!finished) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

endmodule